// File: doc/BRIEF.md
# RTC Event Flag and Interrupt Unit

This block holds the four sticky event flags of a small real-time clock and merges them into a single CPU interrupt request. Two flags record that the minute or the second counter advanced. The counters sit outside the block and report each advance through an increment strobe. The other two flags record periodic ticks at a quarter second and a half second. The block derives both ticks from a 4 Hz timebase strobe.

Software cannot write the flags. It clears a flag in two steps. First it reads the status register while that flag reads 1. Then it reads the data register that owns the flag: the minute register for the minute flag, the second register for the second flag, and the chronograph register for both timebase flags. The block watches the read strobe and read address of the peripheral bus to see this sequence. For each flag it remembers whether the flag was returned as 1 by the last status read. A fresh event that coincides with the clearing read keeps the flag set.

Top module: `rtc_evt_irq`

## Requirements
- R1: A synchronous active-low reset clears all four flags, the interrupt output, every remembered status observation and the half-second divider.
- R2: A minute increment strobe sets the minute flag and a second increment strobe sets the second flag, both at the next clock edge. The status read data carries the minute flag in bit 3, the second flag in bit 2, the half-second flag in bit 1 and the quarter-second flag in bit 0.
- R3: Every 4 Hz strobe sets the quarter-second flag. The half-second flag is set on the 2nd, 4th, 6th and later strobes counted from reset.
- R4: A flag stays set until its clearing sequence completes. A data-register read that follows no status read showing the flag as 1 leaves the flag set.
- R5: A status read that returns the minute flag as 1, followed later by a read of the minute register, clears the minute flag at that read's clock edge. The other flags are left unchanged.
- R6: A status read that returns the second flag as 1, followed later by a read of the second register, clears the second flag at that read's clock edge.
- R7: A read of the chronograph register clears each timebase flag that the preceding status read returned as 1. A timebase flag that was 0 at that status read stays set.
- R8: A matching data-register read uses up the flag's status observation, so a later read of the same register clears nothing without a new status read. Each status read replaces the observation with the flags' values at that read.
- R9: When a set event for a flag coincides with its clearing read, the flag stays 1. Clearing it then needs a new status read.
- R10: The interrupt output is registered. One cycle after any flag is 1 while its enable bit is 1, it is 1; otherwise it is 0. The enable bits use the same bit order as the status data.
- R11: Reads at addresses other than the four decoded registers, and reads of a data register that does not own a flag, do not change that flag or its status observation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_4hz | input | 1 | One-cycle 4 Hz timebase strobe |
| sec_inc | input | 1 | One-cycle second counter increment strobe |
| min_inc | input | 1 | One-cycle minute counter increment strobe |
| irq_en | input | 4 | Interrupt enables, bit order as status data |
| rd_en | input | 1 | Bus read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Bus read register address |
| stat_rdata | output | 4 | Status read data: the current flags |
| irq | output | 1 | Registered CPU interrupt request |

## Verification
A wrong remembered status observation has no effect at the ports until the owning data register is read. The fault then appears on the status data at the very next sample, as a flag that clears when it should stay set or stays set when it should clear. A wrong divider phase moves the half-second flag to odd strobes, which shows at the first or second tick after reset. Because the interrupt is registered, an enable or flag error reaches the interrupt output exactly one cycle after it reaches the status data.

// File: rtl/rtc_evt_pkg.sv
// Shared constants for the RTC event flag unit.
// Assumes four flags; the bit positions are visible to software.
package rtc_evt_pkg;
    localparam int NUM_FLAGS = 4;
    localparam int IDX_TB2   = 0;   // quarter-second tick
    localparam int IDX_TB1   = 1;   // half-second tick
    localparam int IDX_SEC   = 2;   // second increment
    localparam int IDX_MIN   = 3;   // minute increment
endpackage

// File: rtl/rtc_tick_div.sv
// Derives quarter- and half-second tick events from a 4 Hz strobe.
// Assumes tick_4hz is a one-cycle pulse; the 1-bit phase resets to 0,
// so the first half-second event comes on the second strobe.
module rtc_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_4hz,
    output logic qtr_evt,
    output logic half_evt
);
    logic phase_q;

    // Toggle the divider phase on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (tick_4hz)
            phase_q <= ~phase_q;
    end

    assign qtr_evt  = tick_4hz;
    assign half_evt = tick_4hz & phase_q;

    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_4hz |=> $stable(phase_q));
    assert_phase_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_4hz |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/rtc_rd_decode.sv
// Decodes bus reads of the status register and the three data registers.
// Assumes the four addresses are distinct; one read per cycle at most.
module rtc_rd_decode #(
    parameter int                 ADDR_W    = 3,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 'd0,
    parameter logic [ADDR_W-1:0]  MIN_ADDR  = 'd1,
    parameter logic [ADDR_W-1:0]  SEC_ADDR  = 'd2,
    parameter logic [ADDR_W-1:0]  CHR_ADDR  = 'd3
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              stat_rd,
    output logic              min_rd,
    output logic              sec_rd,
    output logic              chr_rd
);
    // Compare the read address against each register address.
    always_comb begin
        stat_rd = rd_en && (rd_addr == STAT_ADDR);
        min_rd  = rd_en && (rd_addr == MIN_ADDR);
        sec_rd  = rd_en && (rd_addr == SEC_ADDR);
        chr_rd  = rd_en && (rd_addr == CHR_ADDR);
    end
endmodule

// File: rtl/rtc_evt_flag.sv
// One sticky event flag with its two-step clearing sequence.
// A status read records the flag value in an arm bit. The owning data-register
// read clears the flag if armed and always consumes the arm bit.
// A set event in the same cycle wins over the clear.
module rtc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic data_rd,
    output logic flag_q
);
    logic arm_q;
    logic clr_go;

    assign clr_go = arm_q & data_rd;

    // Flag: set has priority, then an armed clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (clr_go)
            flag_q <= 1'b0;
    end

    // Arm bit: captured by status reads, consumed by the owning data read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (stat_rd)
            arm_q <= flag_q;
        else if (data_rd)
            arm_q <= 1'b0;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(arm_q && data_rd)) |=> flag_q);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && data_rd && !set_evt) |=> !flag_q);
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (arm_q == $past(flag_q)));
    assert_consume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !stat_rd) |=> !arm_q);
endmodule

// File: rtl/rtc_irq_reg.sv
// Registers the OR of enabled flags into one interrupt request.
// Assumes flags and enables share one bit order.
module rtc_irq_reg #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] flags,
    input  logic [NUM-1:0] enables,
    output logic           irq_q
);
    logic any_pend;

    assign any_pend = |(flags & enables);

    // Register the merged request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= any_pend;
    end

    assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> irq_q);
    assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !irq_q);
endmodule

// File: rtl/rtc_evt_irq.sv
// Top of the RTC event flag and interrupt unit.
// Collects minute, second and timebase events into four sticky flags.
// Each flag is cleared by a status read followed by its owning data-register read.
// Assumes strobes and reads are one-cycle pulses in the clk domain.
module rtc_evt_irq
    import rtc_evt_pkg::*;
#(
    parameter int                 ADDR_W    = 3,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 'd0,
    parameter logic [ADDR_W-1:0]  MIN_ADDR  = 'd1,
    parameter logic [ADDR_W-1:0]  SEC_ADDR  = 'd2,
    parameter logic [ADDR_W-1:0]  CHR_ADDR  = 'd3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_4hz,
    input  logic                 sec_inc,
    input  logic                 min_inc,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NUM_FLAGS-1:0] stat_rdata,
    output logic                 irq
);
    logic                 qtr_evt, half_evt;
    logic                 stat_rd, min_rd, sec_rd, chr_rd;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] own_rd;
    logic [NUM_FLAGS-1:0] flags;

    rtc_tick_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_4hz (tick_4hz),
        .qtr_evt  (qtr_evt),
        .half_evt (half_evt)
    );

    rtc_rd_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .MIN_ADDR  (MIN_ADDR),
        .SEC_ADDR  (SEC_ADDR),
        .CHR_ADDR  (CHR_ADDR)
    ) u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .stat_rd (stat_rd),
        .min_rd  (min_rd),
        .sec_rd  (sec_rd),
        .chr_rd  (chr_rd)
    );

    // Route each flag's set source and owning data read by its index.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        if (i == IDX_MIN) begin : g_min
            assign set_vec[i] = min_inc;
            assign own_rd[i]  = min_rd;
        end else if (i == IDX_SEC) begin : g_sec
            assign set_vec[i] = sec_inc;
            assign own_rd[i]  = sec_rd;
        end else if (i == IDX_TB1) begin : g_tb1
            assign set_vec[i] = half_evt;
            assign own_rd[i]  = chr_rd;
        end else begin : g_tb2
            assign set_vec[i] = qtr_evt;
            assign own_rd[i]  = chr_rd;
        end

        rtc_evt_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[i]),
            .stat_rd (stat_rd),
            .data_rd (own_rd[i]),
            .flag_q  (flags[i])
        );
    end

    assign stat_rdata = flags;

    rtc_irq_reg #(.NUM(NUM_FLAGS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .enables (irq_en),
        .irq_q   (irq)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (stat_rdata == '0 && !irq));
endmodule

// File: tb/rtc_evt_irq_test.sv
module rtc_evt_irq_test;
    localparam logic [2:0] A_STAT = 3'd0, A_MIN = 3'd1, A_SEC = 3'd2, A_CHR = 3'd3, A_OTH = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_4hz = 1'b0, sec_inc = 1'b0, min_inc = 1'b0, rd_en = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic [2:0] rd_addr = 3'd0;
    logic [3:0] stat_rdata;
    logic       irq;

    int n_cmp = 0, n_bad = 0;

    // Reference state kept by the bench.
    logic [3:0] m_flag = 4'h0, m_arm = 4'h0;
    logic       m_div = 1'b0, m_irq = 1'b0;

    always #4 clk = ~clk;

    rtc_evt_irq uut (
        .clk(clk), .rst_n(rst_n), .tick_4hz(tick_4hz), .sec_inc(sec_inc),
        .min_inc(min_inc), .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .stat_rdata(stat_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-state of the reference, from the requirements.
    task automatic model_step(input logic t, s, m, r, input logic [2:0] a);
        logic [3:0] setv, hit, nf, na;
        logic st;
        if (!rst_n) begin
            m_flag = 0; m_arm = 0; m_div = 0; m_irq = 0;
        end else begin
            setv = {m, s, t & m_div, t};
            hit  = {r && a == A_MIN, r && a == A_SEC, r && a == A_CHR, r && a == A_CHR};
            st   = r && a == A_STAT;
            for (int i = 0; i < 4; i++) begin
                nf[i] = setv[i] | (m_flag[i] & ~(m_arm[i] & hit[i]));
                na[i] = st ? m_flag[i] : (hit[i] ? 1'b0 : m_arm[i]);
            end
            m_irq  = |(m_flag & irq_en);
            m_flag = nf; m_arm = na;
            m_div  = m_div ^ t;
        end
    endtask

    task automatic cyc(input logic t, s, m, r, input logic [2:0] a);
        tick_4hz = t; sec_inc = s; min_inc = m; rd_en = r; rd_addr = a;
        model_step(t, s, m, r, a);
        @(posedge clk); #2;
        tick_4hz = 0; sec_inc = 0; min_inc = 0; rd_en = 0; rd_addr = 0;
    endtask

    task automatic idle();         cyc(0, 0, 0, 0, 3'd0); endtask
    task automatic rd(input logic [2:0] a); cyc(0, 0, 0, 1, a); endtask

    initial begin
        #(8 * 200000);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        idle(); idle();
        chk("R1 flags after reset", stat_rdata, 4'b0000);
        chk("R1 irq after reset", {3'b0, irq}, 4'b0000);
        rst_n = 1'b1;
        rd(A_CHR);
        chk("R1 no arm after reset", stat_rdata, 4'b0000);

        // R3 ticks, R2 increments and bit order
        cyc(1, 0, 0, 0, 0); chk("R3 first tick quarter only", stat_rdata, 4'b0001);
        cyc(1, 0, 0, 0, 0); chk("R3 second tick adds half", stat_rdata, 4'b0011);
        cyc(0, 0, 1, 0, 0); chk("R2 minute in bit 3", stat_rdata, 4'b1011);
        cyc(0, 1, 0, 0, 0); chk("R2 second in bit 2", stat_rdata, 4'b1111);
        // R4 unarmed read
        rd(A_MIN); chk("R4 read without status keeps flag", stat_rdata, 4'b1111);
        // R5 R6 R7 clears
        rd(A_STAT); chk("R4 status read does not clear", stat_rdata, 4'b1111);
        rd(A_SEC);  chk("R6 second clear", stat_rdata, 4'b1011);
        rd(A_MIN);  chk("R5 minute clear", stat_rdata, 4'b0011);
        rd(A_CHR);  chk("R7 chronograph clears both", stat_rdata, 4'b0000);

        // R7 half flag not seen at status read stays
        cyc(1, 0, 0, 0, 0); chk("R3 third tick quarter only", stat_rdata, 4'b0001);
        rd(A_STAT);
        cyc(1, 0, 0, 0, 0); chk("R3 fourth tick both", stat_rdata, 4'b0011);
        rd(A_CHR);  chk("R7 unseen half flag kept", stat_rdata, 4'b0010);
        rd(A_STAT); rd(A_CHR); chk("R7 half flag cleared", stat_rdata, 4'b0000);

        // R9 set wins
        cyc(0, 0, 1, 0, 0); rd(A_STAT);
        cyc(0, 0, 1, 1, A_MIN); chk("R9 set beats clear", stat_rdata, 4'b1000);
        rd(A_MIN);  chk("R9 arm dropped after collision", stat_rdata, 4'b1000);
        rd(A_STAT); rd(A_MIN); chk("R9 cleared after fresh status", stat_rdata, 4'b0000);

        // R8 recapture and consumption
        rd(A_STAT); cyc(0, 1, 0, 0, 0);
        rd(A_SEC);  chk("R8 status seen 0 gives no arm", stat_rdata, 4'b0100);
        rd(A_STAT); rd(A_SEC); chk("R8 clear after recapture", stat_rdata, 4'b0000);
        cyc(0, 1, 0, 0, 0);
        rd(A_SEC);  chk("R8 arm consumed by earlier read", stat_rdata, 4'b0100);
        rd(A_STAT);
        // R11 other reads
        rd(A_OTH);  chk("R11 other address ignored", stat_rdata, 4'b0100);
        rd(A_MIN);  chk("R11 foreign data read ignored", stat_rdata, 4'b0100);
        rd(A_SEC);  chk("R11 arm survived foreign reads", stat_rdata, 4'b0000);

        // R10 registered interrupt
        irq_en = 4'b0100;
        cyc(0, 1, 0, 0, 0); chk("R10 irq lags flag", {3'b0, irq}, 4'b0000);
        idle(); chk("R10 irq asserted", {3'b0, irq}, 4'b0001);
        irq_en = 4'b1000; idle(); chk("R10 irq masked", {3'b0, irq}, 4'b0000);
        irq_en = 4'b0100; idle(); chk("R10 irq re-enabled", {3'b0, irq}, 4'b0001);
        rd(A_STAT); rd(A_SEC); chk("R10 irq held one cycle after clear", {3'b0, irq}, 4'b0001);
        idle(); chk("R10 irq drops", {3'b0, irq}, 4'b0000);

        // R1 mid-run reset with flags set and divider advanced
        cyc(1, 1, 1, 0, 0); rd(A_STAT);
        rst_n = 1'b0; idle(); rst_n = 1'b1;
        chk("R1 reset clears flags", stat_rdata, 4'b0000);
        chk("R1 reset clears irq", {3'b0, irq}, 4'b0000);
        cyc(1, 0, 0, 0, 0); chk("R1 divider reset", stat_rdata, 4'b0001);
        rd(A_STAT); rd(A_CHR);

        // Random mix against the reference
        for (int k = 0; k < 3000; k++) begin
            if (k % 50 == 0) irq_en = 4'($urandom);
            cyc(($urandom % 6) == 0, ($urandom % 9) == 0, ($urandom % 13) == 0,
                $urandom[0], 3'($urandom % 6));
            chk("R4 random flags", stat_rdata, m_flag);
            chk("R10 random irq", {3'b0, irq}, {3'b0, m_irq});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule